// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a register-mapped master for the IEEE 802.3 Clause 45 management interface. Software first loads a 16-bit register address into the address register. It then writes the management register with the port address, the device address, an operation code and, for a write, the data. That one write starts the whole transaction. The block sends an address frame that carries the latched register address. It then sends a write frame or a read frame to the same port and device.

The block generates the management clock from the system clock. It drives the data line while it transmits. In a read frame it releases the line during the turnaround and the data field, and it shifts the returned bits in on management-clock rising edges. A busy flag covers both frames without a gap. A read-valid flag and the captured data appear in the management register when a read completes.

Top module: `mdio45_master`

## Requirements
- R1: After reset, both registers read as zero, `mdc` is low and `mdio_oe` is low.
- R2: The address register is at offset 0x8. It keeps only bits 15:0 of the written word and reads back zero-extended. The management register is at offset 0x0.
- R3: A management write with opcode field bits 28:26 equal to 5 (write) or 7 (read), made while idle, starts an address frame. The frame is sent MSB first as start `00`, opcode `00`, port address (bits 20:16 of the write), device address (bits 25:21), turnaround `10`, then the 16-bit register address latched at launch.
- R4: For opcode 5, the second frame is start `00`, opcode `01`, the same port and device, turnaround `10`, and the data from bits 15:0 of the launching write.
- R5: For opcode 7, the second frame carries opcode `11`. The block does not drive the line during the 2 turnaround bits and the 16 data bits. It samples `mdio_i` on `mdc` rising edges. When the frame ends, bit 29 (read-valid) is set and bits 15:0 hold the sampled data, MSB first.
- R6: Each frame is preceded by exactly 32 driven ones.
- R7: Bit 30 (busy) reads 1 from the cycle after the launching write until the data frame ends. It does not drop between the two frames, and it reads 0 once both frames are complete.
- R8: A management write made while busy has no effect. It sends no frame and leaves the opcode, device and port fields unchanged.
- R9: A management write with any opcode other than 5 or 7 has no effect. Busy stays 0, no frame is sent, and the register contents are unchanged.
- R10: Read-valid is cleared in the cycle a new operation is accepted.
- R11: `mdc` is low while idle. During frames its period is 2*CLK_DIV system clocks. `mdio_o` changes only while `mdc` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 4 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data of the register at `csr_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds the block with CLK_DIV=2 and PRE_LEN=32. That makes one management-clock period four system clocks and one frame 256 system clocks. Many complete two-frame transactions therefore fit into a short run, while the preamble keeps its full protocol length. A behavioural PHY decodes every frame against a scoreboard queue and answers read frames with a value derived from port, device and the previous address frame. This covers all-ones and all-zeros fields as well as writes made mid-transaction.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;

  localparam logic [2:0] OPC_WR = 3'd5;
  localparam logic [2:0] OPC_RD = 3'd7;

  localparam logic [3:0] OFS_MGMT = 4'h0;
  localparam logic [3:0] OFS_ADDR = 4'h8;

  localparam logic [1:0] FR_ADDR  = 2'b00;
  localparam logic [1:0] FR_WRITE = 2'b01;
  localparam logic [1:0] FR_READ  = 2'b11;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ADDR = 2'd1,
    SEQ_DATA = 2'd2
  } seq_state_e;

  // Frame body after preamble: ST, OP, port, device, TA, payload (MSB first)
  function automatic logic [31:0] build_frame(input logic [1:0] op,
                                              input logic [4:0] prt,
                                              input logic [4:0] dev,
                                              input logic [1:0] ta,
                                              input logic [15:0] payload);
    return {2'b00, op, prt, dev, ta, payload};
  endfunction

endpackage

// File: rtl/mdio45_mdc_gen.sv
module mdio45_mdc_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic tick_rise,
  output logic tick_fall
);

  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_n;
  logic          mdc_q, mdc_n;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == CW'(CLK_DIV - 1));
    cnt_n = cnt_q;
    mdc_n = mdc_q;
    if (en) begin
      cnt_n = wrap ? '0 : cnt_q + 1'b1;
      if (wrap) mdc_n = ~mdc_q;
    end else begin
      cnt_n = '0;
      mdc_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      mdc_q <= mdc_n;
    end
  end

  assign mdc       = mdc_q;
  assign tick_rise = en && wrap && !mdc_q;
  assign tick_fall = en && wrap && mdc_q;

endmodule

// File: rtl/mdio45_frame_eng.sv
module mdio45_frame_eng #(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] word,
  input  logic        rd,
  input  logic        tick_rise,
  input  logic        tick_fall,
  input  logic        mdio_i,
  output logic        active,
  output logic        done,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] cap_data
);

  localparam int TOTAL = PRE_LEN + 32;
  localparam int IW    = $clog2(TOTAL + 1);

  logic          active_q, active_n;
  logic [IW-1:0] idx_q, idx_n;
  logic [31:0]   word_q, word_n;
  logic          rd_q, rd_n;
  logic [15:0]   cap_q, cap_n;

  logic          last_bit;
  logic          in_body;
  logic [IW-1:0] body_idx;
  logic [4:0]    sel;

  assign last_bit = (idx_q == IW'(TOTAL - 1));
  assign done     = active_q && tick_fall && last_bit;

  always_comb begin
    active_n = active_q;
    idx_n    = idx_q;
    word_n   = word_q;
    rd_n     = rd_q;
    cap_n    = cap_q;
    if (start) begin
      active_n = 1'b1;
      idx_n    = '0;
      word_n   = word;
      rd_n     = rd;
    end else if (active_q && tick_fall) begin
      if (last_bit) active_n = 1'b0;
      else          idx_n    = idx_q + 1'b1;
    end
    if (active_q && rd_q && tick_rise && (idx_q >= IW'(PRE_LEN + 16)))
      cap_n = {cap_q[14:0], mdio_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      word_q   <= '0;
      rd_q     <= 1'b0;
      cap_q    <= '0;
    end else begin
      active_q <= active_n;
      idx_q    <= idx_n;
      word_q   <= word_n;
      rd_q     <= rd_n;
      cap_q    <= cap_n;
    end
  end

  assign in_body  = (idx_q >= IW'(PRE_LEN));
  assign body_idx = idx_q - IW'(PRE_LEN);
  assign sel      = 5'd31 - body_idx[4:0];
  assign mdio_oe  = active_q && !(rd_q && (idx_q >= IW'(PRE_LEN + 14)));
  assign mdio_o   = mdio_oe && (in_body ? word_q[sel] : 1'b1);
  assign active   = active_q;
  assign cap_data = cap_q;

  // R6: a frame's last bit is followed by an idle engine
  a_r6_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active_q);

endmodule

// File: rtl/mdio45_seq.sv
module mdio45_seq
  import mdio45_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mgmt_we,
  input  logic [31:0] mgmt_wdata,
  input  logic [15:0] reg_addr,
  input  logic        eng_done,
  input  logic [15:0] cap_data,
  output logic        busy,
  output logic        eng_start,
  output logic [31:0] eng_word,
  output logic        eng_rd,
  output logic [31:0] mgmt_rdata
);

  seq_state_e  st_q, st_n;
  logic [2:0]  op_q, op_n;
  logic [4:0]  dev_q, dev_n;
  logic [4:0]  prt_q, prt_n;
  logic [15:0] data_q, data_n;
  logic [15:0] ra_q, ra_n;
  logic        rvalid_q, rvalid_n;
  logic        start_q, start_n;

  logic [2:0]  w_op;
  logic        accept;
  logic        is_rd;

  assign w_op   = mgmt_wdata[28:26];
  assign accept = mgmt_we && (st_q == SEQ_IDLE) && ((w_op == OPC_WR) || (w_op == OPC_RD));
  assign is_rd  = (op_q == OPC_RD);

  always_comb begin
    st_n     = st_q;
    op_n     = op_q;
    dev_n    = dev_q;
    prt_n    = prt_q;
    data_n   = data_q;
    ra_n     = ra_q;
    rvalid_n = rvalid_q;
    start_n  = 1'b0;
    unique case (st_q)
      SEQ_IDLE: if (accept) begin
        st_n     = SEQ_ADDR;
        op_n     = w_op;
        dev_n    = mgmt_wdata[25:21];
        prt_n    = mgmt_wdata[20:16];
        data_n   = mgmt_wdata[15:0];
        ra_n     = reg_addr;
        rvalid_n = 1'b0;
        start_n  = 1'b1;
      end
      SEQ_ADDR: if (eng_done) begin
        st_n    = SEQ_DATA;
        start_n = 1'b1;
      end
      SEQ_DATA: if (eng_done) begin
        st_n = SEQ_IDLE;
        if (is_rd) begin
          rvalid_n = 1'b1;
          data_n   = cap_data;
        end
      end
      default: st_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SEQ_IDLE;
      op_q     <= '0;
      dev_q    <= '0;
      prt_q    <= '0;
      data_q   <= '0;
      ra_q     <= '0;
      rvalid_q <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      st_q     <= st_n;
      op_q     <= op_n;
      dev_q    <= dev_n;
      prt_q    <= prt_n;
      data_q   <= data_n;
      ra_q     <= ra_n;
      rvalid_q <= rvalid_n;
      start_q  <= start_n;
    end
  end

  always_comb begin
    if (st_q == SEQ_DATA)
      eng_word = build_frame(is_rd ? FR_READ : FR_WRITE, prt_q, dev_q,
                             is_rd ? 2'b00 : 2'b10, is_rd ? 16'h0000 : data_q);
    else
      eng_word = build_frame(FR_ADDR, prt_q, dev_q, 2'b10, ra_q);
  end

  assign busy       = (st_q != SEQ_IDLE);
  assign eng_start  = start_q;
  assign eng_rd     = (st_q == SEQ_DATA) && is_rd;
  assign mgmt_rdata = {1'b0, busy, rvalid_q, op_q, dev_q, prt_q, data_q};

  // R7: busy only drops when the data frame reports completion
  a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !((st_q == SEQ_DATA) && eng_done) |=> busy);

  // R8: latched fields frozen while a transaction runs
  a_r8_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({op_q, dev_q, prt_q}));

  // R10: a new transaction never starts with read-valid set
  a_r10_rvalid_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !rvalid_q);

  // R5: read-valid only rises at the end of a read
  a_r5_rvalid_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid_q) |-> (op_q == OPC_RD) && !busy);

endmodule

// File: rtl/mdio45_master.sv
module mdio45_master
  import mdio45_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [3:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  logic [15:0] regaddr_q, regaddr_n;
  logic        mgmt_we;
  logic        busy;
  logic        eng_start, eng_rd, eng_active, eng_done;
  logic [31:0] eng_word;
  logic [15:0] cap_data;
  logic [31:0] mgmt_rdata;
  logic        tick_rise, tick_fall;

  assign mgmt_we = csr_we && (csr_addr == OFS_MGMT);

  always_comb begin
    regaddr_n = regaddr_q;
    if (csr_we && (csr_addr == OFS_ADDR)) regaddr_n = csr_wdata[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regaddr_q <= '0;
    else        regaddr_q <= regaddr_n;
  end

  always_comb begin
    unique case (csr_addr)
      OFS_MGMT: csr_rdata = mgmt_rdata;
      OFS_ADDR: csr_rdata = {16'h0000, regaddr_q};
      default:  csr_rdata = '0;
    endcase
  end

  mdio45_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mgmt_we    (mgmt_we),
    .mgmt_wdata (csr_wdata),
    .reg_addr   (regaddr_q),
    .eng_done   (eng_done),
    .cap_data   (cap_data),
    .busy       (busy),
    .eng_start  (eng_start),
    .eng_word   (eng_word),
    .eng_rd     (eng_rd),
    .mgmt_rdata (mgmt_rdata)
  );

  mdio45_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (eng_active),
    .mdc       (mdc),
    .tick_rise (tick_rise),
    .tick_fall (tick_fall)
  );

  mdio45_frame_eng #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (eng_start),
    .word      (eng_word),
    .rd        (eng_rd),
    .tick_rise (tick_rise),
    .tick_fall (tick_fall),
    .mdio_i    (mdio_i),
    .active    (eng_active),
    .done      (eng_done),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .cap_data  (cap_data)
  );

  // R11: data line holds while the management clock is high
  a_r11_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    mdc && $past(mdc) |-> $stable(mdio_o));

  // R11: nothing toggles or drives while idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc && !mdio_oe);

endmodule

// File: tb/mdio45_master_tb.sv
`timescale 1ns/1ps
module mdio45_master_tb_top;

  localparam int DIV    = 2;
  localparam int MDC_NS = 2 * DIV * 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [3:0]  csr_addr = 4'h0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mdio45_master #(.CLK_DIV(DIV), .PRE_LEN(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] d,
                                          input logic [15:0] a);
    return {d, p, 6'h2A} ^ a;
  endfunction

  function automatic logic [31:0] mk(input logic [2:0] op, input logic [4:0] d,
                                     input logic [4:0] p, input logic [15:0] v);
    return {3'b000, op, d, p, v};
  endfunction

  // ---------------- PHY model and frame monitor ----------------
  logic [31:0] exp_q[$];
  int          frames_seen = 0;
  bit          in_frame = 0;
  bit          rd_phase = 0;
  int          ones = 0;
  int          nb = 0;
  logic [31:0] w;
  logic [15:0] last_addr = '0;
  logic [17:0] rsh;
  logic        phy_drv = 1'b0;
  logic        phy_bit = 1'b1;
  time         last_rise = 0;

  assign mdio_i = phy_drv ? phy_bit : 1'b1;

  always @(posedge mdc) begin
    logic b;
    logic [31:0] e;
    if (in_frame) chk(($time - last_rise) == MDC_NS, "R11", "mdc period", 32'($time - last_rise), MDC_NS);
    last_rise = $time;
    if (!in_frame) begin
      if (mdio_oe && mdio_o) ones++;
      else if (mdio_oe && !mdio_o) begin
        chk(ones == 32, "R6", "preamble ones", ones, 32);
        in_frame = 1; nb = 1; w = '0;
      end
    end else begin
      if (rd_phase) begin
        chk(!mdio_oe, "R5", "line released", {31'b0, mdio_oe}, 0);
        b = 1'b0;
      end else b = mdio_oe ? mdio_o : 1'b0;
      w[31-nb] = b;
      nb++;
      if (nb == 14 && w[29:28] == 2'b11) begin
        rd_phase = 1;
        rsh = {2'b10, phy_val(w[27:23], w[22:18], last_addr)};
      end
      if (nb == 32) begin
        if (exp_q.size() == 0) chk(0, "R8", "unexpected frame", w, 0);
        else begin
          e = exp_q.pop_front();
          chk(w == e, (e[29:28] == 2'b00) ? "R3" : (e[29:28] == 2'b01 ? "R4" : "R5"),
              "frame", w, e);
        end
        if (w[29:28] == 2'b00) last_addr = w[15:0];
        in_frame = 0; rd_phase = 0; ones = 0;
        frames_seen++;
      end
    end
  end

  always @(negedge mdc) begin
    if (rd_phase) begin
      phy_drv = 1'b1;
      phy_bit = rsh[17];
      rsh = {rsh[16:0], 1'b0};
    end else phy_drv = 1'b0;
  end

  // ---------------- driver tasks ----------------
  task automatic csr_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0; csr_addr = 4'h0;
    #0.5;
  endtask

  task automatic csr_read(input logic [3:0] a, output logic [31:0] d);
    csr_addr = a;
    #0.5;
    d = csr_rdata;
    csr_addr = 4'h0;
  endtask

  // push expected frames, launch, wait for idle and check busy continuity
  task automatic launch_op(input logic [2:0] op, input logic [4:0] d, input logic [4:0] p,
                           input logic [15:0] v, input logic [15:0] ra);
    logic [31:0] r;
    int f0;
    exp_q.push_back({2'b00, 2'b00, p, d, 2'b10, ra});
    if (op == 3'd5) exp_q.push_back({2'b00, 2'b01, p, d, 2'b10, v});
    else            exp_q.push_back({2'b00, 2'b11, p, d, 18'h0});
    f0 = frames_seen;
    csr_write(4'h0, mk(op, d, p, v));
    csr_read(4'h0, r);
    chk(r[30] == 1'b1, "R7", "busy after launch", r, 32'h4000_0000);
    chk(r[29] == 1'b0, "R10", "read-valid cleared at launch", r, 0);
  endtask

  task automatic wait_idle(input int exp_frames, input int f0);
    logic [31:0] r;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      csr_read(4'h0, r);
      if (!r[30]) break;
    end
    chk(frames_seen - f0 == exp_frames, "R7", "frames done when busy drops",
        frames_seen - f0, exp_frames);
    chk(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // ---------------- test sequence ----------------
  initial begin
    logic [31:0] r, prev;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    csr_read(4'h0, r); chk(r == 0, "R1", "mgmt reset", r, 0);
    csr_read(4'h8, r); chk(r == 0, "R1", "addr reset", r, 0);
    chk(!mdc && !mdio_oe, "R1", "idle pins", {mdc, mdio_oe}, 0);

    // R2 address register keeps low 16 bits
    csr_write(4'h8, 32'hDEAD_BEEF);
    csr_read(4'h8, r); chk(r == 32'h0000_BEEF, "R2", "addr readback", r, 32'h0000_BEEF);
    csr_read(4'h0, r); chk(r == 0, "R2", "mgmt untouched", r, 0);

    // R3/R4 write transaction, with ignored write mid-way (R8)
    f0 = frames_seen;
    launch_op(3'd5, 5'h01, 5'h03, 16'h1234, 16'hBEEF);
    repeat (20) @(negedge clk);
    csr_write(4'h0, mk(3'd7, 5'h1F, 5'h1F, 16'hAAAA));
    csr_read(4'h0, r);
    chk(r[28:16] == {3'd5, 5'h01, 5'h03}, "R8", "fields while busy", r[28:16], {3'd5, 5'h01, 5'h03});
    chk(r[30], "R8", "still busy", r, 32'h4000_0000);
    wait_idle(2, f0);
    csr_read(4'h0, r);
    chk(r[30:29] == 2'b00, "R7", "idle after write", r[30:29], 0);

    // R5 read transaction
    csr_write(4'h8, 32'h0000_0042);
    f0 = frames_seen;
    launch_op(3'd7, 5'h07, 5'h1C, 16'h0000, 16'h0042);
    wait_idle(2, f0);
    csr_read(4'h0, r);
    chk(r[29], "R5", "read-valid set", r, 32'h2000_0000);
    chk(r[15:0] == phy_val(5'h1C, 5'h07, 16'h0042), "R5", "read data", r[15:0],
        {16'h0, phy_val(5'h1C, 5'h07, 16'h0042)});

    // R9 invalid opcode ignored
    prev = r;
    f0 = frames_seen;
    csr_write(4'h0, mk(3'd3, 5'h05, 5'h05, 16'h5555));
    csr_read(4'h0, r); chk(r == prev, "R9", "reg unchanged", r, prev);
    repeat (300) @(negedge clk);
    chk(frames_seen == f0, "R9", "no frames", frames_seen, f0);
    csr_read(4'h0, r); chk(r == prev, "R9", "reg still unchanged", r, prev);

    // R10 new write clears read-valid; extreme fields with all-zero data (R4)
    csr_write(4'h8, 32'h0000_0000);
    f0 = frames_seen;
    launch_op(3'd5, 5'h00, 5'h00, 16'h0000, 16'h0000);
    wait_idle(2, f0);

    // boundary read: all-ones fields and address
    csr_write(4'h8, 32'h0001_FFFF);
    f0 = frames_seen;
    launch_op(3'd7, 5'h1F, 5'h1F, 16'h0000, 16'hFFFF);
    wait_idle(2, f0);
    csr_read(4'h0, r);
    chk(r[15:0] == phy_val(5'h1F, 5'h1F, 16'hFFFF), "R5", "boundary read data", r[15:0],
        {16'h0, phy_val(5'h1F, 5'h1F, 16'hFFFF)});
    chk(r[28:16] == {3'd7, 5'h1F, 5'h1F}, "R3", "latched fields", r[28:16], {3'd7, 5'h1F, 5'h1F});

    // all-ones write data
    f0 = frames_seen;
    launch_op(3'd5, 5'h12, 5'h09, 16'hFFFF, 16'hFFFF);
    wait_idle(2, f0);
    csr_read(4'h0, r);
    chk(r[29] == 1'b0, "R10", "no read-valid after write", r, 0);
    chk(!mdc && !mdio_oe, "R11", "idle after ops", {mdc, mdio_oe}, 0);

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule